// File: doc/BRIEF.md
# Sub-Second Real-Time Counter with Delayed Register Writes

The block keeps time with two chained counters: a fractional counter that advances on every slow tick and wraps at a configurable modulus, and a whole-seconds counter that takes the carry from that wrap. Each counter has its own alarm register and its own interrupt status bit. A control register gives separate count enables and interrupt enables for the two counters.

Software reaches the block through a synchronous word-addressed register port. Writes do not land at once: each one is held in a per-register pending slot and applied a fixed number of slow ticks later, which stands in for a crossing into a slow clock domain. While a slot is pending its busy flag reads high. Writing a register whose previous write is still pending is refused and raises a sticky error flag; the value already in flight still lands.

Top module: `rtc_subsec_wtrack`

## Requirements
- R1: The register index is byte address bits [4:2]: 0x00 fractional counter, 0x04 seconds counter, 0x08 fractional alarm, 0x0C seconds alarm, 0x10 control, 0x14 status, 0x18 interrupt clear; the interrupt clear register always reads 0.
- R2: A write to 0x00..0x10 becomes visible on the LAT-th tick after the write cycle; its busy flag (status bit 4 + register index, so bits 4..8) is high from the cycle after the write until that tick.
- R3: Status bit 3 reads 1 exactly when any of the seven busy flags (status bits 4..10) is 1.
- R4: A write to a register whose busy flag is set sets status bit 2 (sticky), is discarded, and the earlier pending value still completes unchanged.
- R5: Any write to the status register (0x14), whatever its data, clears status bit 2 in the next cycle.
- R6: With control bit 0 set, each tick advances the fractional counter, which wraps from SUB_MOD-1 to 0; on that wrap the seconds counter increments if control bit 1 is set.
- R7: With control bit 0 clear the fractional counter holds its value on ticks; with control bit 1 clear the seconds counter holds its value even when the fractional counter wraps.
- R8: Status bit 0 sets (sticky) on a tick that advances the fractional counter onto the fractional alarm value; status bit 1 sets on a tick that advances the seconds counter onto the seconds alarm value; this happens regardless of the interrupt enables.
- R9: Output irq_sub equals status bit 0 AND control bit 2; output irq_sec equals status bit 1 AND control bit 3.
- R10: Writing 0x18 with data bit 0 set starts a pending clear (busy status bit 9) that clears status bit 0 after LAT ticks; data bit 1 does the same for status bit 1 (busy bit 10); a zero data bit starts nothing.
- R11: After reset every counter, alarm, control bit, status bit and interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe marking a slow-domain tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte address of the register |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for addr, combinational |
| irq_sub | output | 1 | Fractional-counter alarm interrupt |
| irq_sec | output | 1 | Seconds-counter alarm interrupt |

## Verification
The bench builds the block with SUB_MOD of 5, a write latency of 3 ticks, a 3-bit fractional counter, an 8-bit seconds counter and 16-bit data. The short modulus puts several fractional wraps, carries and alarm hits into a few dozen ticks, so every tick of a long run is compared against an arithmetic count in the bench, and the three-tick latency makes the before, during and after views of every pending write, collision and clear cheap to sample.

// File: rtl/rtc_wt_pkg.sv
// Shared constants and types for the sub-second counter with delayed writes.
// Assumes the register index is the byte address divided by four.
package rtc_wt_pkg;

    localparam int NCH = 7;          // number of pending-write slots

    // Pending-write slot numbers; slot n drives status busy bit 4+n.
    localparam int CH_SUB  = 0;
    localparam int CH_SEC  = 1;
    localparam int CH_SALM = 2;
    localparam int CH_CALM = 3;
    localparam int CH_CTRL = 4;
    localparam int CH_SCLR = 5;
    localparam int CH_CCLR = 6;

    // Register indices (byte address bits [4:2]).
    localparam logic [2:0] IDX_SUB  = 3'd0;
    localparam logic [2:0] IDX_SEC  = 3'd1;
    localparam logic [2:0] IDX_SALM = 3'd2;
    localparam logic [2:0] IDX_CALM = 3'd3;
    localparam logic [2:0] IDX_CTRL = 3'd4;
    localparam logic [2:0] IDX_STAT = 3'd5;
    localparam logic [2:0] IDX_ICLR = 3'd6;

    // Control register, bit 0 is the LSB (last member).
    typedef struct packed {
        logic sec_ie;   // bit 3
        logic sub_ie;   // bit 2
        logic sec_en;   // bit 1
        logic sub_en;   // bit 0
    } ctrl_t;

endpackage

// File: rtl/rtc_wt_tracker.sv
// Pending-write tracker: one slot per writable target. A launch into an idle
// slot captures the data and counts LAT ticks; on the last tick the slot
// pulses done and frees. A launch into a busy slot is dropped and sets a
// sticky error, cleared by err_clr. Assumes LAT >= 1 and at most one launch
// collision source per cycle.
module rtc_wt_tracker #(
    parameter int NCH = 7,
    parameter int DW  = 32,
    parameter int LAT = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic [NCH-1:0]           launch,
    input  logic [DW-1:0]            wdata,
    input  logic                     err_clr,
    output logic [NCH-1:0]           busy,
    output logic [NCH-1:0]           done,
    output logic [NCH-1:0][DW-1:0]   hold,
    output logic                     err
);
    localparam int CW = $clog2(LAT + 1);

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_slot
            logic [CW-1:0] cnt;

            // Completion strobe on the last tick of the latency window.
            assign done[i] = busy[i] & tick & (cnt == CW'(1));

            // Slot state: capture on idle launch, count down on ticks.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    busy[i] <= 1'b0;
                    cnt     <= '0;
                    hold[i] <= '0;
                end else if (launch[i] && !busy[i]) begin
                    busy[i] <= 1'b1;
                    cnt     <= CW'(LAT);
                    hold[i] <= wdata;
                end else if (busy[i] && tick) begin
                    if (cnt == CW'(1)) begin
                        busy[i] <= 1'b0;
                    end
                    cnt <= cnt - CW'(1);
                end
            end

            // R4: a colliding launch neither frees the slot early nor alters its data.
            p_collide_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (launch[i] && busy[i] && !done[i]) |=> (busy[i] && hold[i] == $past(hold[i])));

            // R2: a completed slot reads idle in the following cycle.
            p_done_frees_r2: assert property (@(posedge clk) disable iff (!rst_n)
                done[i] |=> !busy[i]);
        end
    endgenerate

    // Sticky error: set on a collision, cleared by a status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (err_clr) begin
            err <= 1'b0;
        end else if (|(launch & busy)) begin
            err <= 1'b1;
        end
    end

    // R4: a collision raises the error flag.
    p_err_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(launch & busy) && !err_clr) |=> err);

    // R5: a status write clears the error flag.
    p_err_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> !err);

endmodule

// File: rtl/rtc_wt_core.sv
// Time-keeping core: fractional and seconds counters, alarms, control and
// interrupt status. Completed writes from the tracker override counting in
// the same tick. Status sets win over a clear completing in the same tick.
// Assumes DW >= SEC_W, DW >= SUB_W and SUB_MOD <= 2**SUB_W.
module rtc_wt_core
    import rtc_wt_pkg::*;
#(
    parameter int DW      = 32,
    parameter int SUB_W   = 15,
    parameter int SEC_W   = 32,
    parameter int SUB_MOD = 32768
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic [NCH-1:0]         done,
    input  logic [NCH-1:0][DW-1:0] hold,
    output logic [SUB_W-1:0]       sub_cnt,
    output logic [SEC_W-1:0]       sec_cnt,
    output logic [SUB_W-1:0]       sub_alm,
    output logic [SEC_W-1:0]       sec_alm,
    output ctrl_t                  ctrl,
    output logic [1:0]             st
);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_MOD - 1);

    logic             sub_inc, sub_wrap, sec_inc, sub_hit, sec_hit;
    logic [SUB_W-1:0] sub_nx;
    logic [SEC_W-1:0] sec_nx;

    // Advance decisions and next values for this tick.
    always_comb begin
        sub_wrap = (sub_cnt == SUB_LAST);
        sub_inc  = tick & ctrl.sub_en;
        sub_nx   = sub_wrap ? '0 : sub_cnt + SUB_W'(1);
        sec_inc  = sub_inc & sub_wrap & ctrl.sec_en;
        sec_nx   = sec_cnt + SEC_W'(1);
        sub_hit  = sub_inc & ~done[CH_SUB] & (sub_nx == sub_alm);
        sec_hit  = sec_inc & ~done[CH_SEC] & (sec_nx == sec_alm);
    end

    // Counters: a landing write wins over counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_cnt <= '0;
            sec_cnt <= '0;
        end else begin
            if (done[CH_SUB])      sub_cnt <= hold[CH_SUB][SUB_W-1:0];
            else if (sub_inc)      sub_cnt <= sub_nx;
            if (done[CH_SEC])      sec_cnt <= hold[CH_SEC][SEC_W-1:0];
            else if (sec_inc)      sec_cnt <= sec_nx;
        end
    end

    // Alarm and control registers load when their pending write lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_alm <= '0;
            sec_alm <= '0;
            ctrl    <= '0;
        end else begin
            if (done[CH_SALM]) sub_alm <= hold[CH_SALM][SUB_W-1:0];
            if (done[CH_CALM]) sec_alm <= hold[CH_CALM][SEC_W-1:0];
            if (done[CH_CTRL]) ctrl    <= ctrl_t'(hold[CH_CTRL][3:0]);
        end
    end

    // Sticky alarm status with delayed clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= 2'b00;
        end else begin
            if (sub_hit)             st[0] <= 1'b1;
            else if (done[CH_SCLR])  st[0] <= 1'b0;
            if (sec_hit)             st[1] <= 1'b1;
            else if (done[CH_CCLR])  st[1] <= 1'b0;
        end
    end

    // R6: the fractional counter wraps to zero after its last value.
    p_sub_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_inc && sub_wrap && !done[CH_SUB]) |=> (sub_cnt == '0));

    // R6: the wrap carries one into the seconds counter when enabled.
    p_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_inc && sub_wrap && ctrl.sec_en && !done[CH_SEC])
        |=> (sec_cnt == $past(sec_cnt) + SEC_W'(1)));

    // R7: a disabled fractional counter keeps its value.
    p_sub_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.sub_en && !done[CH_SUB]) |=> $stable(sub_cnt));

    // R8: reaching the fractional alarm raises status bit 0.
    p_sub_alarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sub_hit |=> st[0]);

    // R10: a landed clear drops the status bit unless a hit coincides.
    p_sub_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done[CH_SCLR] && !sub_hit) |=> !st[0]);

endmodule

// File: rtl/rtc_subsec_wtrack.sv
// Top level: decodes the register port into pending-write launches, muxes
// read data and gates the interrupt outputs. Reads are combinational and
// side-effect free. Assumes DW >= 11 so the status word fits.
module rtc_subsec_wtrack
    import rtc_wt_pkg::*;
#(
    parameter int DW      = 32,
    parameter int SUB_W   = 15,
    parameter int SEC_W   = 32,
    parameter int SUB_MOD = 32768,
    parameter int LAT     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [4:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq_sub,
    output logic          irq_sec
);
    logic [2:0]             idx;
    logic [NCH-1:0]         launch, busy, done;
    logic [NCH-1:0][DW-1:0] hold;
    logic                   err, err_clr;
    logic [SUB_W-1:0]       sub_cnt, sub_alm;
    logic [SEC_W-1:0]       sec_cnt, sec_alm;
    ctrl_t                  ctrl;
    logic [1:0]             st;

    assign idx = addr[4:2];

    // Write decode: one launch per targeted slot, clears only for set bits.
    always_comb begin
        launch          = '0;
        launch[CH_SUB]  = wr_en && (idx == IDX_SUB);
        launch[CH_SEC]  = wr_en && (idx == IDX_SEC);
        launch[CH_SALM] = wr_en && (idx == IDX_SALM);
        launch[CH_CALM] = wr_en && (idx == IDX_CALM);
        launch[CH_CTRL] = wr_en && (idx == IDX_CTRL);
        launch[CH_SCLR] = wr_en && (idx == IDX_ICLR) && wdata[0];
        launch[CH_CCLR] = wr_en && (idx == IDX_ICLR) && wdata[1];
        err_clr         = wr_en && (idx == IDX_STAT);
    end

    rtc_wt_tracker #(.NCH(NCH), .DW(DW), .LAT(LAT)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .launch  (launch),
        .wdata   (wdata),
        .err_clr (err_clr),
        .busy    (busy),
        .done    (done),
        .hold    (hold),
        .err     (err)
    );

    rtc_wt_core #(.DW(DW), .SUB_W(SUB_W), .SEC_W(SEC_W), .SUB_MOD(SUB_MOD)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .done    (done),
        .hold    (hold),
        .sub_cnt (sub_cnt),
        .sec_cnt (sec_cnt),
        .sub_alm (sub_alm),
        .sec_alm (sec_alm),
        .ctrl    (ctrl),
        .st      (st)
    );

    // Read mux; the clear register and unused index read zero.
    always_comb begin
        unique case (idx)
            IDX_SUB:  rdata = DW'(sub_cnt);
            IDX_SEC:  rdata = DW'(sec_cnt);
            IDX_SALM: rdata = DW'(sub_alm);
            IDX_CALM: rdata = DW'(sec_alm);
            IDX_CTRL: rdata = DW'(ctrl);
            IDX_STAT: rdata = DW'({busy, |busy, err, st});
            default:  rdata = '0;
        endcase
    end

    // Interrupt outputs gated by their enables.
    assign irq_sub = st[0] & ctrl.sub_ie;
    assign irq_sec = st[1] & ctrl.sec_ie;

    // R2: a write into an idle slot shows as busy in the next cycle.
    p_launch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_SUB && !busy[CH_SUB]) |=> busy[CH_SUB]);

    // R10: a clear write with data bit 0 low starts no fractional clear.
    p_noclr_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_ICLR && !wdata[0] && !busy[CH_SCLR]) |=> !busy[CH_SCLR]);

endmodule

// File: tb/rtc_subsec_wtrack_bench.sv
// Bench: small configuration, arithmetic model of counters and alarm flags.
module rtc_subsec_wtrack_bench;
    localparam int DW = 16, SUB_W = 3, SEC_W = 8, MOD = 5, LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq_sub, irq_sec;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // bench model
    int m_s = 0, m_c = 0, m_salm = 0, m_calm = 0;
    bit m_sen = 0, m_cen = 0, f_s = 0, f_c = 0;

    always #2.5 clk = ~clk;

    rtc_subsec_wtrack #(.DW(DW), .SUB_W(SUB_W), .SEC_W(SEC_W), .SUB_MOD(MOD), .LAT(LAT))
        u_rtc_subsec_wtrack (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_sub(irq_sub), .irq_sec(irq_sec));

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 5'(a); wdata = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        addr = 5'(a);
        #1;
        v = int'(rdata);
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        if (m_sen) begin
            m_s = (m_s + 1) % MOD;
            if (m_s == m_salm) f_s = 1;
            if (m_s == 0 && m_cen) begin
                m_c = (m_c + 1) % 256;
                if (m_c == m_calm) f_c = 1;
            end
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state, R1 every register reads zero
        for (int a = 0; a < 7; a++) begin
            rd(a * 4, v);
            chk("R11 reset register", v, 0);
        end
        chk("R11 irq_sub reset", int'(irq_sub), 0);
        chk("R11 irq_sec reset", int'(irq_sec), 0);

        // R2 latency and R3 busy-any
        wr(8'h00, 3);
        rd(8'h14, v); chk("R2 R3 busy after write", v, 32'h18);
        rd(8'h00, v); chk("R2 value not yet applied", v, 0);
        ticks(2);
        rd(8'h00, v); chk("R2 value before last tick", v, 0);
        rd(8'h14, v); chk("R2 still busy", v, 32'h18);
        ticks(1);
        rd(8'h00, v); chk("R2 value applied", v, 3);
        rd(8'h14, v); chk("R3 busy cleared", v, 0);
        m_s = 3;

        // R4 collision, R5 error clear
        wr(8'h08, 2);
        wr(8'h08, 4);
        rd(8'h14, v); chk("R4 error and busy", v, 32'h4C);
        ticks(3);
        rd(8'h08, v); chk("R4 first value kept", v, 2);
        rd(8'h14, v); chk("R4 error sticky", v, 32'h04);
        wr(8'h14, 0);
        rd(8'h14, v); chk("R5 error cleared", v, 0);
        m_salm = 2;

        // R1 offsets: three writes pending at once
        wr(8'h04, 7);
        wr(8'h0C, 8);
        wr(8'h10, 32'hF);
        rd(8'h14, v); chk("R1 R3 busy bits 5 7 8", v, 32'h1A8);
        ticks(3);
        rd(8'h04, v);  chk("R1 seconds register", v, 7);
        rd(8'h0C, v);  chk("R1 seconds alarm", v, 8);
        rd(8'h10, v);  chk("R1 control", v, 32'hF);
        m_c = 7; m_calm = 8; m_sen = 1; m_cen = 1;

        // R6 counting sweep with carries, R8 alarm flags
        for (int i = 0; i < 12; i++) begin
            do_tick();
            rd(8'h00, v); chk("R6 fractional count", v, m_s);
            rd(8'h04, v); chk("R6 seconds count", v, m_c);
            rd(8'h14, v); chk("R8 status flags", v & 3, (int'(f_c) << 1) | int'(f_s));
        end
        chk("R9 irq_sub on", int'(irq_sub), int'(f_s));
        chk("R9 irq_sec on", int'(irq_sec), int'(f_c));

        // R9 gate: only fractional interrupt enabled, counting stops
        wr(8'h10, 32'h4);
        ticks(3);
        m_sen = 0; m_cen = 0;
        chk("R9 irq_sub enabled", int'(irq_sub), 1);
        chk("R9 irq_sec masked", int'(irq_sec), 0);
        rd(8'h14, v); chk("R9 status kept", v, 3);
        rd(8'h00, v); chk("R6 count during latency", v, m_s);

        // R7 disabled counters hold
        ticks(4);
        rd(8'h00, v); chk("R7 fractional holds", v, m_s);
        rd(8'h04, v); chk("R7 seconds holds", v, m_c);

        // R10 delayed clears
        wr(8'h18, 1);
        rd(8'h14, v); chk("R10 clear busy bit 9", v, 32'h20B);
        ticks(3);
        rd(8'h14, v); chk("R10 fractional cleared", v, 2);
        chk("R10 irq_sub dropped", int'(irq_sub), 0);
        wr(8'h18, 0);
        rd(8'h14, v); chk("R10 zero data starts nothing", v, 2);
        wr(8'h18, 2);
        rd(8'h14, v); chk("R10 clear busy bit 10", v, 32'h40A);
        ticks(3);
        rd(8'h14, v); chk("R10 seconds cleared", v, 0);
        f_s = 0; f_c = 0;

        // R7 fractional runs, seconds disabled
        wr(8'h10, 32'h1);
        ticks(3);
        m_sen = 1;
        for (int i = 0; i < 6; i++) begin
            do_tick();
            rd(8'h00, v); chk("R7 fractional runs", v, m_s);
            rd(8'h04, v); chk("R7 seconds frozen", v, m_c);
        end
        rd(8'h14, v); chk("R8 flag with interrupt off", v & 3, int'(f_s));
        chk("R9 irq_sub masked", int'(irq_sub), 0);
        rd(8'h18, v); chk("R1 clear reads zero", v, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule